// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block performs exception entry for a processor core once a cause has been chosen. Each cause maps to a fixed target mode and vector offset. A control bit can move the vector into the high vector region. The block first asks the banked-register logic to switch to the target mode. It then commits the new architectural state: the saved copy of the old status word, the rewritten status word with interrupts masked, the link value and the new program counter.

The sequence takes three states: idle, switch and commit. When a legal cause is accepted, the mode-switch request appears for one cycle. In the following cycle the committed values appear together with a one-cycle done pulse. A cause code with no mapping raises a one-cycle error flag and leaves every output register unchanged. Choosing among competing causes and restarting fetch are left to the surrounding core.

Top module: `exc_entry_seq`

## Requirements
- R1: Cause code 1 (privileged call) enters mode 0x13 with vector offset 0x08.
- R2: Cause code 2 (instruction trap) enters mode 0x17 with offset 0x0C. Cause code 3 (data trap) enters mode 0x17 with offset 0x10.
- R3: Cause code 4 (interrupt) enters mode 0x12 with offset 0x18.
- R4: When `hivec` is high at acceptance, the new PC is the offset plus 0xFFFF0000. Otherwise the new PC is the offset alone.
- R5: A cause is accepted at a clock edge where the block is idle and `cause_valid` is high. In the cycle after that edge, `mode_req_valid` is high for exactly one cycle and `mode_req` carries the target mode. This happens before any state is committed.
- R6: `saved_status` receives the complete status word as it was when the cause was accepted.
- R7: `status_out` equals the old status word with bits [4:0] replaced by the target mode and bit 7 (interrupt mask) set. All other bits are kept.
- R8: `link_out` receives the PC captured at acceptance, and `pc_out` receives the vector address.
- R9: A cause code outside 1..4 raises `err_unhandled` for one cycle after the accepting edge. It requests no mode switch, produces no done pulse and changes no output register.
- R10: `done` is high for exactly one cycle, the cycle after the mode request. The committed outputs first show their new values in that cycle. `busy` is high from the switch state through commit, and `cause_valid` is ignored while `busy` is high.
- R11: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cause_valid | input | 1 | Cause strobe |
| cause | input | 3 | Exception cause code |
| status_in | input | 32 | Current status word |
| pc_in | input | 32 | Current program counter |
| hivec | input | 1 | High-vector relocation enable |
| busy | output | 1 | Sequence in progress |
| mode_req_valid | output | 1 | Mode-switch request strobe |
| mode_req | output | 5 | Requested target mode |
| status_out | output | 32 | New status word |
| saved_status | output | 32 | Saved pre-exception status |
| link_out | output | 32 | Value for the link register |
| pc_out | output | 32 | New program counter (vector) |
| done | output | 1 | Commit pulse; outputs valid |
| err_unhandled | output | 1 | Unmapped cause pulse |

## Verification
Two things can coincide with an entry already in flight: a fresh strobe, and the commit of that entry. The bench holds `cause_valid` high with a different cause through the switch and commit cycles. It then checks that the committed PC and mode belong to the first cause and that no second request follows. An unmapped cause is also sent straight after a completed entry. The bench then checks that the error pulse arrives with no request and that the previously committed registers still hold their values.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int MODE_W = 5;

  localparam logic [MODE_W-1:0] MODE_PRIV = 5'h13;
  localparam logic [MODE_W-1:0] MODE_TRAP = 5'h17;
  localparam logic [MODE_W-1:0] MODE_IRQ  = 5'h12;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SWITCH = 2'd1,
    ST_COMMIT = 2'd2
  } seq_state_e;

endpackage

// File: rtl/exc_cause_decode.sv
module exc_cause_decode
  import exc_entry_pkg::*;
#(
  parameter int CAUSE_W = 3,
  parameter int OFF_W   = 8
) (
  input  logic [CAUSE_W-1:0] cause,
  output logic               legal,
  output logic [MODE_W-1:0]  mode,
  output logic [OFF_W-1:0]   offset
);

  always_comb begin
    legal  = 1'b1;
    mode   = '0;
    offset = '0;
    case (cause)
      CAUSE_W'(1): begin mode = MODE_PRIV; offset = OFF_W'(8'h08); end
      CAUSE_W'(2): begin mode = MODE_TRAP; offset = OFF_W'(8'h0C); end
      CAUSE_W'(3): begin mode = MODE_TRAP; offset = OFF_W'(8'h10); end
      CAUSE_W'(4): begin mode = MODE_IRQ;  offset = OFF_W'(8'h18); end
      default:     legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen #(
  parameter int          XLEN       = 32,
  parameter int          OFF_W      = 8,
  parameter logic [31:0] HIVEC_BASE = 32'hFFFF0000
) (
  input  logic [OFF_W-1:0] offset,
  input  logic             hivec,
  output logic [XLEN-1:0]  vector
);

  localparam logic [XLEN-1:0] BASE = XLEN'(HIVEC_BASE);

  always_comb begin
    vector = XLEN'(offset);
    if (hivec) vector = BASE + XLEN'(offset);
  end

endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
  import exc_entry_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic switch_act,
  output logic commit_act
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (start) state_d = ST_SWITCH;
      ST_SWITCH: state_d = ST_COMMIT;
      ST_COMMIT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy       = (state_q != ST_IDLE);
  assign switch_act = (state_q == ST_SWITCH);
  assign commit_act = (state_q == ST_COMMIT);

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          CAUSE_W    = 3,
  parameter int          IMASK_BIT  = 7,
  parameter logic [31:0] HIVEC_BASE = 32'hFFFF0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cause_valid,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [XLEN-1:0]    status_in,
  input  logic [XLEN-1:0]    pc_in,
  input  logic               hivec,
  output logic               busy,
  output logic               mode_req_valid,
  output logic [MODE_W-1:0]  mode_req,
  output logic [XLEN-1:0]    status_out,
  output logic [XLEN-1:0]    saved_status,
  output logic [XLEN-1:0]    link_out,
  output logic [XLEN-1:0]    pc_out,
  output logic               done,
  output logic               err_unhandled
);

  localparam int OFF_W = 8;

  logic              legal;
  logic [MODE_W-1:0] dec_mode;
  logic [OFF_W-1:0]  dec_off;
  logic [XLEN-1:0]   vec;
  logic              accept_en, reject_en, switch_act;

  logic [MODE_W-1:0] mode_q;
  logic [XLEN-1:0]   vec_q, stat_q, pc_q;
  logic [XLEN-1:0]   status_d;
  logic              err_q;
  logic [XLEN-1:0]   st_out_q, sv_out_q, lk_out_q, pc_out_q;

  exc_cause_decode #(.CAUSE_W(CAUSE_W), .OFF_W(OFF_W)) u_dec (
    .cause (cause),
    .legal (legal),
    .mode  (dec_mode),
    .offset(dec_off)
  );

  exc_vector_gen #(.XLEN(XLEN), .OFF_W(OFF_W), .HIVEC_BASE(HIVEC_BASE)) u_vec (
    .offset(dec_off),
    .hivec (hivec),
    .vector(vec)
  );

  assign accept_en = cause_valid && !busy && legal;
  assign reject_en = cause_valid && !busy && !legal;

  exc_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept_en),
    .busy      (busy),
    .switch_act(switch_act),
    .commit_act(done)
  );

  // capture stage, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      vec_q  <= '0;
      stat_q <= '0;
      pc_q   <= '0;
    end else if (accept_en) begin
      mode_q <= dec_mode;
      vec_q  <= vec;
      stat_q <= status_in;
      pc_q   <= pc_in;
    end
  end

  // new status: mode field replaced, interrupt mask set
  always_comb begin
    status_d                 = stat_q;
    status_d[MODE_W-1:0]     = mode_q;
    status_d[IMASK_BIT]      = 1'b1;
  end

  // commit stage, enabled while switch request is out
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_out_q <= '0;
      sv_out_q <= '0;
      lk_out_q <= '0;
      pc_out_q <= '0;
    end else if (switch_act) begin
      st_out_q <= status_d;
      sv_out_q <= stat_q;
      lk_out_q <= pc_q;
      pc_out_q <= vec_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= reject_en;
  end

  assign mode_req_valid = switch_act;
  assign mode_req       = mode_q;
  assign status_out     = st_out_q;
  assign saved_status   = sv_out_q;
  assign link_out       = lk_out_q;
  assign pc_out         = pc_out_q;
  assign err_unhandled  = err_q;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN      = 32,
  parameter int MODE_W    = 5,
  parameter int IMASK_BIT = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_req_valid,
  input logic [MODE_W-1:0] mode_req,
  input logic [XLEN-1:0]   status_out,
  input logic [XLEN-1:0]   saved_status,
  input logic [XLEN-1:0]   link_out,
  input logic [XLEN-1:0]   pc_out,
  input logic              done,
  input logic              err_unhandled
);

  localparam logic [XLEN-1:0] KEEP_MASK =
    ~((XLEN'(1) << IMASK_BIT) | ((XLEN'(1) << MODE_W) - XLEN'(1)));

  assert_mode_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mode_req_valid));

  assert_req_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_req_valid |=> (!mode_req_valid && done));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_unhandled |-> (!mode_req_valid && !done));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(pc_out) && $stable(status_out) &&
               $stable(link_out) && $stable(saved_status)));

  assert_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status_out[IMASK_BIT] && (status_out[MODE_W-1:0] == mode_req) &&
              ((status_out & KEEP_MASK) == (saved_status & KEEP_MASK))));

endmodule

bind exc_entry_seq exc_entry_chk #(
  .XLEN(XLEN), .MODE_W(exc_entry_pkg::MODE_W), .IMASK_BIT(IMASK_BIT)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_req_valid(mode_req_valid),
  .mode_req      (mode_req),
  .status_out    (status_out),
  .saved_status  (saved_status),
  .link_out      (link_out),
  .pc_out        (pc_out),
  .done          (done),
  .err_unhandled (err_unhandled)
);

// File: tb/exc_entry_seq_test.sv
`timescale 1ns/1ps
module exc_entry_seq_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cause_valid;
  logic [2:0]  cause;
  logic [31:0] status_in, pc_in;
  logic        hivec;
  logic        busy, mode_req_valid, done, err_unhandled;
  logic [4:0]  mode_req;
  logic [31:0] status_out, saved_status, link_out, pc_out;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  exc_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .cause_valid(cause_valid), .cause(cause),
    .status_in(status_in), .pc_in(pc_in), .hivec(hivec), .busy(busy),
    .mode_req_valid(mode_req_valid), .mode_req(mode_req),
    .status_out(status_out), .saved_status(saved_status),
    .link_out(link_out), .pc_out(pc_out), .done(done),
    .err_unhandled(err_unhandled)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_mode(input logic [2:0] c);
    case (c)
      3'd1: return 5'h13;
      3'd4: return 5'h12;
      default: return 5'h17;
    endcase
  endfunction

  function automatic logic [31:0] exp_vec(input logic [2:0] c, input logic hv);
    logic [31:0] o;
    case (c)
      3'd1: o = 32'h08;
      3'd2: o = 32'h0C;
      3'd3: o = 32'h10;
      default: o = 32'h18;
    endcase
    return hv ? o + 32'hFFFF0000 : o;
  endfunction

  task automatic t_reset;
    rst_n = 1'b0; cause_valid = 1'b0; cause = '0; status_in = '0; pc_in = '0; hivec = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !mode_req_valid && !done && !err_unhandled, "R11 ctrl", 32'(busy), 0);
    check(status_out == 0 && saved_status == 0 && link_out == 0 && pc_out == 0,
          "R11 data", pc_out, 0);
  endtask

  // one entry; hold_extra keeps a different strobe active through the sequence
  task automatic t_entry(input logic [2:0] c, input logic [31:0] st,
                         input logic [31:0] pc, input logic hv, input string req,
                         input bit hold_extra);
    logic [31:0] es;
    es = (st & ~32'h1F) | 32'(exp_mode(c)) | 32'h80;
    @(negedge clk);
    cause_valid = 1'b1; cause = c; status_in = st; pc_in = pc; hivec = hv;
    @(negedge clk);
    if (hold_extra) begin
      cause = 3'd4; status_in = 32'h0; pc_in = 32'h1; hivec = ~hv;
    end else cause_valid = 1'b0;
    check(mode_req_valid && busy && !done, {req, " R5 req"}, 32'(mode_req_valid), 1);
    check(mode_req == exp_mode(c), {req, " mode R5"}, 32'(mode_req), 32'(exp_mode(c)));
    @(negedge clk);
    cause_valid = 1'b0;
    check(done && !mode_req_valid, "R10 done", 32'(done), 1);
    check(pc_out == exp_vec(c, hv), {req, " R4 R8 pc"}, pc_out, exp_vec(c, hv));
    check(link_out == pc, "R8 link", link_out, pc);
    check(saved_status == st, "R6 saved", saved_status, st);
    check(status_out == es, "R7 status", status_out, es);
    @(negedge clk);
    check(!done && !busy && !mode_req_valid, "R10 pulse end", 32'(done), 0);
    check(pc_out == exp_vec(c, hv), "R10 ignored strobe pc", pc_out, exp_vec(c, hv));
  endtask

  task automatic t_unhandled(input logic [2:0] c);
    logic [31:0] p0, s0, l0, v0;
    p0 = pc_out; s0 = status_out; l0 = link_out; v0 = saved_status;
    @(negedge clk);
    cause_valid = 1'b1; cause = c; status_in = 32'hDEAD_BEEF; pc_in = 32'h1234_5678; hivec = 1'b1;
    @(negedge clk);
    cause_valid = 1'b0;
    check(err_unhandled && !mode_req_valid && !busy, "R9 err pulse", 32'(err_unhandled), 1);
    @(negedge clk);
    check(!err_unhandled && !done && !mode_req_valid, "R9 err end", 32'(err_unhandled), 0);
    check(pc_out == p0 && status_out == s0, "R9 hold pc", pc_out, p0);
    check(link_out == l0 && saved_status == v0, "R9 hold link", link_out, l0);
  endtask

  initial begin
    t_reset();
    t_entry(3'd1, 32'h0000_0010, 32'h0000_4000, 1'b0, "R1", 1'b0);
    t_entry(3'd2, 32'hA5A5_A513, 32'h8000_0100, 1'b0, "R2", 1'b0);
    t_entry(3'd3, 32'hFFFF_FF7F, 32'h0000_0ABC, 1'b1, "R2", 1'b0);
    t_entry(3'd4, 32'h1234_5660, 32'hCAFE_0000, 1'b1, "R3", 1'b0);
    t_entry(3'd1, 32'h0000_0000, 32'hFFFF_FFFC, 1'b1, "R1", 1'b1);
    t_unhandled(3'd0);
    t_unhandled(3'd5);
    t_unhandled(3'd7);
    t_entry(3'd2, 32'h0000_001F, 32'h0000_0004, 1'b0, "R2", 1'b1);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule